// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a serial configuration slave for a small byte-wide register space. It uses three wires: a serial clock, an active-low select and one shared data pin. The shared pin is presented as an input, an output and an output enable, and the pad ring joins them. The serial clock and select are sampled in the block's own clock domain through a short synchronizer. Every frame opens with a 16-bit command word that carries the direction, a word-count code and a 13-bit register address. One or more 8-bit data words follow the command.

On a write frame, each received word lands in the addressed register. On a read frame, the block takes over the data pin once the command word is complete, and it shifts register contents out on falling serial clock edges. After each word the address moves to the next one. The direction of that move follows the data bit order, and one configuration bit chooses the bit order. The select may be held low to stream words without limit. It may also rise between words of a counted frame to pause the frame without losing it.

The register contents are exposed as a flat image, so that neighbouring logic can use the configuration.

Top module: `spi3w_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, `sdio_oe` is low, and data words use most-significant-bit-first order.
- R2: A frame begins when select falls, and bits are sampled on rising serial clock edges. The first 16 bits are always taken in this order: direction (1 = read, 0 = write), a 2-bit length code, then address bits 12 down to 0.
- R3: The length code sets the data word count: 00 gives one word, 01 gives two, 10 gives three, and 11 streams words until select rises.
- R4: On a write, each completed 8-bit word is stored into the register at the current address. A write to an address at or above the register count changes no register.
- R5: On a read, `sdio_oe` rises after the 16th command bit, and each data bit is launched on a falling serial clock edge before the rising edge that samples it. Addresses at or above the register count return 0x00.
- R6: After each word, the address steps by one, modulo 2^13. It steps down in most-significant-first order and up in least-significant-first order.
- R7: Bit 0 of register 0 set to 1 selects least-significant-first order for the data words of frames that begin after it is written. The order stays fixed for the rest of a frame, and the command word order never changes.
- R8: In a counted frame, select rising on a word boundary of the data phase pauses the frame. Select falling again resumes it at the next word with the same direction and address.
- R9: Select rising during the command word, or in the middle of a data word, discards the frame. The partial word is not stored.
- R10: `sdio_oe` is low whenever select is high. Once a counted frame has moved all its words, further serial clocks are ignored until select rises: nothing is written and the pin is not driven.
- R11: In a streaming frame, select rising on a word boundary ends the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| csn | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Data pin as seen by the block |
| sdio_out | output | 1 | Data the block drives onto the pin during reads |
| sdio_oe | output | 1 | Drive enable for the data pin |
| reg_image | output | NUM_REGS*8 | All register contents, register i at bits [8i+7:8i] |

## Verification
The assertions assume the serial clock runs several block clocks per phase. They also assume that no select edge lands in the same synchronized cycle as a serial clock edge, so each sampled event is seen on its own. The bench keeps every serial clock half-period at six block clocks. It leaves six block clocks between a select edge and the next clock edge, and it changes the data pin only while the serial clock is low. Under those assumptions, the properties on output launch timing, drive enable, write timing and address stepping describe the intended protocol rather than artifacts of colliding events.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  localparam int INSTR_BITS = 16;
  localparam int ADDR_W     = 13;
  localparam int WORD_W     = 8;
  localparam int BITCNT_W   = $clog2(INSTR_BITS);

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_INSTR,
    FS_DATA,
    FS_PAUSE,
    FS_DONE
  } frame_state_e;

  typedef enum logic [1:0] {
    LEN_ONE    = 2'b00,
    LEN_TWO    = 2'b01,
    LEN_THREE  = 2'b10,
    LEN_STREAM = 2'b11
  } word_len_e;

  typedef struct packed {
    logic              is_read;
    word_len_e         len;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  // Address after one word; wraps modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic lsb_first);
    return lsb_first ? a + 1'b1 : a - 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] bit_reverse(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction

  // Map a register value to the order it travels on the wire (MSB of result goes first)
  function automatic logic [WORD_W-1:0] wire_order(input logic [WORD_W-1:0] v,
                                                   input logic lsb_first);
    return lsb_first ? bit_reverse(v) : v;
  endfunction

  // True when the word now completing is the last of a counted frame
  function automatic logic is_final_word(input logic [1:0] len_code,
                                         input logic [1:0] done_before);
    return (len_code != LEN_STREAM) && (done_before == len_code);
  endfunction

endpackage

// File: rtl/spi3w_edge_sync.sv
module spi3w_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic csn_pin,
  input  logic sdi_pin,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csn_level,
  output logic csn_rise,
  output logic csn_fall,
  output logic sdi_level
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0]  sclk_pipe;
  logic [DEPTH-1:0]  csn_pipe;
  logic [STAGES-1:0] sdi_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '0;
      csn_pipe  <= '1;
      sdi_pipe  <= '0;
    end else begin
      sclk_pipe <= DEPTH'({sclk_pipe, sclk_pin});
      csn_pipe  <= DEPTH'({csn_pipe, csn_pin});
      sdi_pipe  <= STAGES'({sdi_pipe, sdi_pin});
    end
  end

  // New value at STAGES-1, previous value at STAGES; data tap aligned with the new clock value
  assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES];
  assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_pipe[STAGES];
  assign csn_level = csn_pipe[STAGES-1];
  assign csn_rise  = csn_pipe[STAGES-1] & ~csn_pipe[STAGES];
  assign csn_fall  = ~csn_pipe[STAGES-1] & csn_pipe[STAGES];
  assign sdi_level = sdi_pipe[STAGES-1];

endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile
  import spi3w_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int CFG_INDEX = 0,
  parameter int ORDER_BIT = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       lsb_first_cfg,
  output logic [NUM_REGS*WORD_W-1:0] image
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return 32'(a) < NUM_REGS;
  endfunction

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && in_range(wr_addr) && (wr_addr[IDX_W-1:0] == IDX_W'(i))) begin
          q <= wr_data;
        end
      end
      assign image[i*WORD_W +: WORD_W] = q;
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (in_range(rd_addr)) rd_data = image[rd_addr[IDX_W-1:0]*WORD_W +: WORD_W];
  end

  assign lsb_first_cfg = image[CFG_INDEX*WORD_W + ORDER_BIT];

endmodule

// File: rtl/spi3w_frame_ctrl.sv
module spi3w_frame_ctrl
  import spi3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csn_level,
  input  logic              csn_rise,
  input  logic              csn_fall,
  input  logic              sdi_level,
  input  logic              lsb_first_cfg,
  input  logic [WORD_W-1:0] fetch_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              instr_done,
  output logic              word_done,
  output logic              abort_ev,
  output logic              frame_active,
  output logic              lsb_active,
  output logic [ADDR_W-1:0] cur_addr
);
  frame_state_e          state;
  logic [BITCNT_W-1:0]   bit_cnt;
  logic [INSTR_BITS-2:0] instr_sh;
  logic [WORD_W-2:0]     rx_sh;
  logic [WORD_W-1:0]     tx_sh;
  logic                  sdo_q;
  logic                  is_read;
  word_len_e             len;
  logic [ADDR_W-1:0]     addr;
  logic [1:0]            words_done;
  logic                  lsb_q;

  instr_t                instr_full;
  logic [WORD_W-1:0]     rx_full;
  logic                  in_instr;
  logic                  in_data;
  logic                  on_boundary;
  logic                  pause_ev;
  logic                  last_word;

  assign instr_full  = instr_t'({instr_sh, sdi_level});
  assign rx_full     = {rx_sh, sdi_level};
  assign in_instr    = (state == FS_INSTR);
  assign in_data     = (state == FS_DATA);
  assign on_boundary = (bit_cnt == '0);

  assign instr_done = in_instr && !csn_rise && sclk_rise &&
                      (bit_cnt == BITCNT_W'(INSTR_BITS - 1));
  assign word_done  = in_data && !csn_rise && sclk_rise &&
                      (bit_cnt == BITCNT_W'(WORD_W - 1));
  assign abort_ev   = csn_rise && (in_instr || (in_data && !on_boundary));
  assign pause_ev   = csn_rise && in_data && on_boundary && (len != LEN_STREAM);
  assign last_word  = is_final_word(len, words_done);

  // One read port: command address while the command word completes, else the stepped address
  assign fetch_addr = in_instr ? instr_full.addr : next_addr(addr, lsb_q);

  assign wr_en   = word_done && !is_read;
  assign wr_addr = addr;
  assign wr_data = lsb_q ? bit_reverse(rx_full) : rx_full;

  assign sdo          = sdo_q;
  assign sdo_en       = in_data && is_read && !csn_level;
  assign frame_active = (state != FS_IDLE);
  assign lsb_active   = lsb_q;
  assign cur_addr     = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FS_IDLE;
      bit_cnt    <= '0;
      instr_sh   <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sdo_q      <= 1'b0;
      is_read    <= 1'b0;
      len        <= LEN_ONE;
      addr       <= '0;
      words_done <= '0;
      lsb_q      <= 1'b0;
    end else begin
      case (state)
        FS_IDLE: begin
          if (csn_fall) begin
            state   <= FS_INSTR;
            bit_cnt <= '0;
            lsb_q   <= lsb_first_cfg;
          end
        end
        FS_INSTR: begin
          if (csn_rise) begin
            state <= FS_IDLE;
          end else if (sclk_rise) begin
            instr_sh <= {instr_sh[INSTR_BITS-3:0], sdi_level};
            bit_cnt  <= bit_cnt + 1'b1;
            if (instr_done) begin
              is_read    <= instr_full.is_read;
              len        <= instr_full.len;
              addr       <= instr_full.addr;
              words_done <= '0;
              bit_cnt    <= '0;
              tx_sh      <= wire_order(fetch_data, lsb_q);
              state      <= FS_DATA;
            end
          end
        end
        FS_DATA: begin
          if (csn_rise) begin
            state <= pause_ev ? FS_PAUSE : FS_IDLE;
          end else if (sclk_rise) begin
            rx_sh   <= rx_full[WORD_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (word_done) begin
              bit_cnt    <= '0;
              addr       <= fetch_addr;
              words_done <= (words_done == 2'b11) ? 2'b11 : words_done + 1'b1;
              if (is_read) tx_sh <= wire_order(fetch_data, lsb_q);
              if (last_word) state <= FS_DONE;
            end
          end else if (sclk_fall && is_read) begin
            sdo_q <= tx_sh[WORD_W-1];
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
          end
        end
        FS_PAUSE: begin
          if (csn_fall) state <= FS_DATA;
        end
        FS_DONE: begin
          if (csn_rise) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi3w_cfg_port.sv
module spi3w_cfg_port
  import spi3w_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_INDEX   = 0,
  parameter int ORDER_BIT   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       csn,
  input  logic                       sdio_in,
  output logic                       sdio_out,
  output logic                       sdio_oe,
  output logic [NUM_REGS*WORD_W-1:0] reg_image
);
  logic              sclk_rise;
  logic              sclk_fall;
  logic              csn_level;
  logic              csn_rise;
  logic              csn_fall;
  logic              sdi_level;
  logic              lsb_first_cfg;
  logic [WORD_W-1:0] fetch_data;
  logic [ADDR_W-1:0] fetch_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              instr_done;
  logic              word_done;
  logic              abort_ev;
  logic              frame_active;
  logic              lsb_active;
  logic [ADDR_W-1:0] cur_addr;

  spi3w_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_pin  (sclk),
    .csn_pin   (csn),
    .sdi_pin   (sdio_in),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .csn_level (csn_level),
    .csn_rise  (csn_rise),
    .csn_fall  (csn_fall),
    .sdi_level (sdi_level)
  );

  spi3w_frame_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclk_rise     (sclk_rise),
    .sclk_fall     (sclk_fall),
    .csn_level     (csn_level),
    .csn_rise      (csn_rise),
    .csn_fall      (csn_fall),
    .sdi_level     (sdi_level),
    .lsb_first_cfg (lsb_first_cfg),
    .fetch_data    (fetch_data),
    .fetch_addr    (fetch_addr),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .sdo           (sdio_out),
    .sdo_en        (sdio_oe),
    .instr_done    (instr_done),
    .word_done     (word_done),
    .abort_ev      (abort_ev),
    .frame_active  (frame_active),
    .lsb_active    (lsb_active),
    .cur_addr      (cur_addr)
  );

  spi3w_regfile #(
    .NUM_REGS  (NUM_REGS),
    .CFG_INDEX (CFG_INDEX),
    .ORDER_BIT (ORDER_BIT)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (fetch_addr),
    .rd_data       (fetch_data),
    .lsb_first_cfg (lsb_first_cfg),
    .image         (reg_image)
  );

endmodule

// File: rtl/spi3w_cfg_port_chk.sv
module spi3w_cfg_port_chk
  import spi3w_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              csn_level,
  input logic              csn_fall,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              instr_done,
  input logic              word_done,
  input logic              abort_ev,
  input logic              wr_en,
  input logic              frame_active,
  input logic              lsb_active,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              sdio_out,
  input logic              sdio_oe
);

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !csn_level);  // R10

  AST_DRIVE_STARTS_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> ($past(instr_done) || $past(csn_fall)));  // R5

  AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && (sdio_out != $past(sdio_out))) |-> $past(sclk_fall));  // R5

  AST_WRITE_ON_SAMPLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sclk_rise && !sdio_oe));  // R4

  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cur_addr != $past(cur_addr)));  // R6

  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && $past(frame_active)) |-> (lsb_active == $past(lsb_active)));  // R7

  AST_ABORT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> !frame_active);  // R9

  AST_CMD_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> frame_active);  // R2

endmodule

bind spi3w_cfg_port spi3w_cfg_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csn_level    (csn_level),
  .csn_fall     (csn_fall),
  .sclk_rise    (sclk_rise),
  .sclk_fall    (sclk_fall),
  .instr_done   (instr_done),
  .word_done    (word_done),
  .abort_ev     (abort_ev),
  .wr_en        (wr_en),
  .frame_active (frame_active),
  .lsb_active   (lsb_active),
  .cur_addr     (cur_addr),
  .sdio_out     (sdio_out),
  .sdio_oe      (sdio_oe)
);

// File: tb/spi3w_cfg_port_test.sv
module spi3w_cfg_port_test;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic sdio_in = 1'b0;
  logic sdio_out;
  logic sdio_oe;
  logic [NREG*8-1:0] reg_image;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int csn_high_run = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  spi3w_cfg_port #(.NUM_REGS(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .reg_image(reg_image)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Model: which order frames use, next address, what a read returns
  function automatic bit model_lsb();
    return model[0][0];
  endfunction

  function automatic logic [12:0] step(input logic [12:0] a, input bit lsb);
    int n;
    n = (int'(a) + (lsb ? 1 : 8191)) % 8192;
    return n[12:0];
  endfunction

  function automatic logic [7:0] expect_rd(input logic [12:0] a);
    return (int'(a) < NREG) ? model[a[2:0]] : 8'h00;
  endfunction

  task automatic model_store(input logic [12:0] a, input logic [7:0] v);
    if (int'(a) < NREG) model[a[2:0]] = v;
  endtask

  task automatic check_image(input string req);
    logic [NREG*8-1:0] e;
    for (int i = 0; i < NREG; i++) e[i*8 +: 8] = model[i];
    check(reg_image === e, req, "register image", reg_image, e);
  endtask

  // Every clock: once select has been high a while the pin must be released (R10)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      csn_high_run = csn ? csn_high_run + 1 : 0;
      if (csn_high_run > 4) check(sdio_oe === 1'b0, "R10", "drive while deselected", sdio_oe, 0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic b, output logic got, output logic oe);
    sdio_in = b;
    wait_clk(6);
    got = sdio_out;
    oe = sdio_oe;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
  endtask

  task automatic select();
    csn = 1'b0;
    wait_clk(6);
  endtask

  task automatic deselect();
    wait_clk(6);
    csn = 1'b1;
    wait_clk(8);
  endtask

  task automatic send_bits(input logic [15:0] w, input int count);
    logic g, o;
    for (int i = 15; i > 15 - count; i--) tick(w[i], g, o);
  endtask

  task automatic send_cmd(input bit rd, input logic [1:0] len, input logic [12:0] a);
    send_bits({rd, len, a}, 16);
  endtask

  task automatic push_byte(input logic [7:0] v, input bit lsb, input int count);
    logic g, o;
    for (int k = 0; k < count; k++) tick(lsb ? v[k] : v[7-k], g, o);
  endtask

  task automatic pull_byte(input bit lsb, output logic [7:0] v, output bit all_oe);
    logic g, o;
    all_oe = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick(1'b0, g, o);
      v[lsb ? k : 7-k] = g;
      if (o !== 1'b1) all_oe = 1'b0;
    end
  endtask

  task automatic write_frame(input logic [12:0] a, input logic [1:0] len,
                             input logic [7:0] data[$], input bit pause, input string req);
    bit lsb;
    logic [12:0] p;
    lsb = model_lsb();
    p = a;
    select();
    send_cmd(1'b0, len, a);
    foreach (data[i]) begin
      push_byte(data[i], lsb, 8);
      model_store(p, data[i]);
      p = step(p, lsb);
      if (pause && i == 0) begin
        deselect();
        select();
      end
    end
    deselect();
    check_image(req);
  endtask

  task automatic read_frame(input logic [12:0] a, input logic [1:0] len, input int n,
                            input bit pause, input string req);
    bit lsb, all_oe;
    logic [12:0] p;
    logic [7:0] v;
    lsb = model_lsb();
    p = a;
    select();
    send_cmd(1'b1, len, a);
    for (int i = 0; i < n; i++) begin
      pull_byte(lsb, v, all_oe);
      check(all_oe, req, "pin driven during read word", all_oe, 1);
      check(v === expect_rd(p), req, $sformatf("read word at %0h", p), v, expect_rd(p));
      p = step(p, lsb);
      if (pause && i == 0) begin
        deselect();
        select();
      end
    end
    deselect();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic g, o;
    logic [7:0] v;
    bit all_oe;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R1: reset state
    check(sdio_oe === 1'b0, "R1", "oe after reset", sdio_oe, 0);
    check_image("R1");

    // R2 R4: single-word write, command order fixed
    write_frame(13'd3, 2'b00, '{8'hA5}, 1'b0, "R2 R4");

    // R3 R6: three-word write steps the address down
    write_frame(13'd7, 2'b10, '{8'h11, 8'h22, 8'h33}, 1'b0, "R3 R6");

    // R5 R3: two-word read
    read_frame(13'd7, 2'b01, 2, 1'b0, "R5 R3");

    // R4 R5: unimplemented address is write-ignored and reads zero
    write_frame(13'h100, 2'b00, '{8'hFF}, 1'b0, "R4");
    read_frame(13'h100, 2'b00, 1, 1'b0, "R5");

    // R11: streaming write ends when select rises
    write_frame(13'd4, 2'b11, '{8'h44, 8'h55, 8'h66, 8'h77}, 1'b0, "R11");

    // R6: streaming read wraps below address 0
    read_frame(13'd2, 2'b11, 5, 1'b0, "R6 R11");

    // R8: paused counted frames
    write_frame(13'd6, 2'b01, '{8'h88, 8'h99}, 1'b1, "R8");
    read_frame(13'd6, 2'b01, 2, 1'b1, "R8");

    // R9: abort inside the command word, then a clean frame
    select();
    send_bits({1'b0, 2'b00, 13'd3}, 10);
    deselect();
    check_image("R9");
    write_frame(13'd2, 2'b00, '{8'hC3}, 1'b0, "R9");

    // R9: abort in the middle of a data word
    select();
    send_cmd(1'b0, 2'b00, 13'd1);
    push_byte(8'hF0, 1'b0, 5);
    deselect();
    check_image("R9");

    // R10: extra word after a finished one-word write is ignored
    select();
    send_cmd(1'b0, 2'b00, 13'd4);
    push_byte(8'h5A, 1'b0, 8);
    model_store(13'd4, 8'h5A);
    push_byte(8'hE1, 1'b0, 8);
    deselect();
    check_image("R10");

    // R10: no drive after a finished one-word read
    select();
    send_cmd(1'b1, 2'b00, 13'd4);
    pull_byte(1'b0, v, all_oe);
    check(v === model[4], "R10", "read before finish", v, model[4]);
    for (int k = 0; k < 8; k++) begin
      tick(1'b0, g, o);
      check(o === 1'b0, "R10", "oe after final word", o, 0);
    end
    deselect();

    // R7: enable least-significant-first order, takes effect next frame
    write_frame(13'd0, 2'b00, '{8'h01}, 1'b0, "R7");
    write_frame(13'd2, 2'b01, '{8'hB4, 8'h0D}, 1'b0, "R7 R6");
    read_frame(13'd2, 2'b01, 2, 1'b0, "R7 R6");
    write_frame(13'd0, 2'b00, '{8'h00}, 1'b0, "R7");
    read_frame(13'd3, 2'b00, 1, 1'b0, "R7");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule